// File: doc/BRIEF.md
# Active-Low Network Interrupt Aggregator

This block gathers per-port network interrupt requests from a board's expansion slots into a single level interrupt line for the CPU. It holds one 16-bit status word per slot group. In each word a bit at 0 marks a pending source and a bit at 1 marks an idle source. A raise request names a slot and a port. A fixed slot map picks the status word and a bit offset, and the request drives bit (offset + port) of that word low. A withdraw request with the same slot and port drives the bit high again.

The interrupt line is registered. It is high whenever any status word holds a 0 bit. A small synchronous register bus gives read-only access to the status words. The same bus also carries a 16-bit mask register, which is plain storage and gates nothing in this block.

Top module: `netirq_agg`

## Requirements
- R1: After reset every status word reads 0xFFFF, the mask reads 0x0000, `irq_out` is low and `bus_rdata` is 0.
- R2: A raise request (`pend_req`) for slot s and port p drives bit p of status word s to 0. Slot 0 maps to word 0 with offset 0, slot 1 maps to word 1 with offset 0. All other bits are left unchanged.
- R3: A withdraw request (`drop_req`) for slot s and port p drives that same bit back to 1 and leaves all other bits unchanged.
- R4: When a raise and a withdraw hit the same bit in the same cycle, the bit ends at 0. When they hit different bits, both take effect.
- R5: `irq_out` is high exactly when some status word differs from 0xFFFF. It follows the status words with one clock of delay.
- R6: A read strobe captures `bus_addr`, and `bus_rdata` shows the result in the next cycle. Address 0x26 returns word 0, 0x28 returns word 1 and 0x30 returns the mask. Any other address returns 0. A cycle with no read strobe leaves `bus_rdata` at 0 in the next cycle.
- R7: Writes to 0x26 or 0x28 leave the status words unchanged.
- R8: A write to 0x30 stores `bus_wdata` in the mask, and the mask reads back the last value written. The mask value has no effect on `irq_out`.
- R9: A raise or withdraw request that names a slot number of 2 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_req | input | 1 | Raise request strobe |
| pend_slot | input | 2 | Slot of the raise request |
| pend_port | input | 4 | Port of the raise request |
| drop_req | input | 1 | Withdraw request strobe |
| drop_slot | input | 2 | Slot of the withdraw request |
| drop_port | input | 4 | Port of the withdraw request |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Combined level interrupt, active high |

## Verification
The bench aims at the active-low polarity and at the two requests colliding. A design that let the withdraw win a same-bit collision would drop a live interrupt. A design that treated a set bit as pending would fire the interrupt right after reset.

The bench also samples `irq_out` in the cycle right after a status change, where the old level must still be showing. A combinational output or a two-stage output would be caught there.

Further checks cover the following cases:
- writes aimed at the read-only words, which a loose decoder would let corrupt the status;
- an out-of-range slot number, which a decoder that truncates the slot would alias onto slot 0;
- an unmapped read address, which must return 0;
- a mask write, which must leave the interrupt level untouched.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2
   } rd_sel_e;

   // Slot-to-word map: each slot owns its own status word.
   function automatic int unsigned slot_word(int unsigned slot);
      return slot;
   endfunction

   // Slot-to-bit-offset map: every slot starts at bit 0 of its word.
   function automatic int unsigned slot_offset(int unsigned slot);
      case (slot)
         0:       return 0;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/netirq_status_word.sv
module netirq_status_word #(
   parameter int WORD_W = 16,
   localparam int IDX_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend_en,
   input  logic [IDX_W-1:0]  pend_idx,
   input  logic              drop_en,
   input  logic [IDX_W-1:0]  drop_idx,
   output logic [WORD_W-1:0] word_q
);
   logic [WORD_W-1:0] word_d;

   // The withdraw is applied first, so a raise of the same bit wins.
   always_comb begin
      word_d = word_q;
      if (drop_en) word_d[drop_idx] = 1'b1;
      if (pend_en) word_d[pend_idx] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '1;
      else        word_q <= word_d;
   end
endmodule

// File: rtl/netirq_combine.sv
module netirq_combine #(
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 2,
   parameter bit IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] words [NUM_WORDS],
   output logic              irq
);
   logic any_pend;

   always_comb begin
      any_pend = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (words[w] != '1) any_pend = 1'b1;
   end

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_pend;
         end
         assign irq = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = any_pend;
      end
   endgenerate
endmodule

// File: rtl/netirq_regbus.sv
module netirq_regbus
   import netirq_pkg::*;
#(
   parameter int                WORD_W    = 16,
   parameter int                NUM_WORDS = 2,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_BASE = 8'h26,
   parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h30,
   localparam int               WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] words [NUM_WORDS],
   output logic [WORD_W-1:0] rdata,
   output logic [WORD_W-1:0] mask_q
);
   rd_sel_e           sel;
   logic [WSEL_W-1:0] wsel;

   // Status words sit at even offsets starting at STAT_BASE.
   always_comb begin
      sel  = SEL_NONE;
      wsel = '0;
      if (addr == MASK_OFS) sel = SEL_MASK;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (addr == STAT_BASE + ADDR_W'(2 * w)) begin
            sel  = SEL_STAT;
            wsel = WSEL_W'(w);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         case (sel)
            SEL_STAT: rdata <= words[wsel];
            SEL_MASK: rdata <= mask_q;
            default:  rdata <= '0;
         endcase
      end else begin
         rdata <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       mask_q <= '0;
      else if (wr && addr == MASK_OFS)  mask_q <= wdata;
   end
endmodule

// File: rtl/netirq_agg.sv
module netirq_agg
   import netirq_pkg::*;
#(
   parameter int                WORD_W    = 16,
   parameter int                NUM_WORDS = 2,
   parameter int                NUM_SLOTS = 2,
   parameter int                SLOT_W    = 2,
   parameter int                PORT_W    = 4,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_BASE = 8'h26,
   parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h30,
   parameter bit                IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend_req,
   input  logic [SLOT_W-1:0] pend_slot,
   input  logic [PORT_W-1:0] pend_port,
   input  logic              drop_req,
   input  logic [SLOT_W-1:0] drop_slot,
   input  logic [PORT_W-1:0] drop_port,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              irq_out
);
   localparam int IDX_W = $clog2(WORD_W);

   generate
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_w
         $error("WORD_W must be a power of two of at least 2");
      end
      if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << SLOT_W)) begin : g_bad_s
         $error("NUM_SLOTS does not fit SLOT_W");
      end
      if (MASK_OFS >= STAT_BASE && MASK_OFS < STAT_BASE + ADDR_W'(2 * NUM_WORDS)) begin : g_bad_a
         $error("MASK_OFS overlaps the status words");
      end
   endgenerate

   logic [WORD_W-1:0] stat_q [NUM_WORDS];
   logic [WORD_W-1:0] mask_q;

   int unsigned pend_pos, drop_pos;
   logic        pend_ok, drop_ok;

   always_comb begin
      pend_pos = slot_offset(int'(pend_slot)) + int'(pend_port);
      drop_pos = slot_offset(int'(drop_slot)) + int'(drop_port);
      pend_ok  = pend_req && int'(pend_slot) < NUM_SLOTS && pend_pos < WORD_W;
      drop_ok  = drop_req && int'(drop_slot) < NUM_SLOTS && drop_pos < WORD_W;
   end

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic pend_hit, drop_hit;
         assign pend_hit = pend_ok && slot_word(int'(pend_slot)) == w;
         assign drop_hit = drop_ok && slot_word(int'(drop_slot)) == w;

         netirq_status_word #(.WORD_W(WORD_W)) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend_en  (pend_hit),
            .pend_idx (pend_pos[IDX_W-1:0]),
            .drop_en  (drop_hit),
            .drop_idx (drop_pos[IDX_W-1:0]),
            .word_q   (stat_q[w])
         );
      end
   endgenerate

   netirq_combine #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IRQ_REG(IRQ_REG)
   ) u_comb (
      .clk   (clk),
      .rst_n (rst_n),
      .words (stat_q),
      .irq   (irq_out)
   );

   netirq_regbus #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W),
      .STAT_BASE(STAT_BASE), .MASK_OFS(MASK_OFS)
   ) u_bus (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd     (bus_rd),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .words  (stat_q),
      .rdata  (bus_rdata),
      .mask_q (mask_q)
   );
endmodule

// File: rtl/netirq_chk.sv
module netirq_chk #(
   parameter int                WORD_W    = 16,
   parameter int                NUM_WORDS = 2,
   parameter int                NUM_SLOTS = 2,
   parameter int                SLOT_W    = 2,
   parameter int                PORT_W    = 4,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h30,
   parameter bit                IRQ_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pend_req,
   input logic [SLOT_W-1:0] pend_slot,
   input logic [PORT_W-1:0] pend_port,
   input logic              drop_req,
   input logic [SLOT_W-1:0] drop_slot,
   input logic [PORT_W-1:0] drop_port,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WORD_W-1:0] bus_rdata,
   input logic              irq_out,
   input logic [WORD_W-1:0] stat_q [NUM_WORDS],
   input logic [WORD_W-1:0] mask_q
);
   logic any_pend;
   always_comb begin
      any_pend = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (stat_q[w] != '1) any_pend = 1'b1;
   end

   logic pend_v, drop_v, same_bit;
   assign pend_v   = pend_req && int'(pend_slot) < NUM_SLOTS && int'(pend_port) < WORD_W;
   assign drop_v   = drop_req && int'(drop_slot) < NUM_SLOTS && int'(drop_port) < WORD_W;
   assign same_bit = pend_v && pend_slot == drop_slot && pend_port == drop_port;

   // Remember last cycle's request targets so the result can be checked.
   logic              pend_q, drop_q;
   logic [SLOT_W-1:0] pend_s_q, drop_s_q;
   logic [PORT_W-1:0] pend_p_q, drop_p_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0; drop_q <= 1'b0;
         pend_s_q <= '0; drop_s_q <= '0; pend_p_q <= '0; drop_p_q <= '0;
      end else begin
         pend_q <= pend_v; drop_q <= drop_v && !same_bit;
         pend_s_q <= pend_slot; drop_s_q <= drop_slot;
         pend_p_q <= pend_port; drop_p_q <= drop_port;
      end
   end

   AST_PEND_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> stat_q[pend_s_q][pend_p_q] == 1'b0);                   // R2
   AST_DROP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      drop_q |-> stat_q[drop_s_q][drop_p_q] == 1'b1);                   // R3
   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);                                     // R6
   AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == MASK_OFS) |=> $stable(mask_q));           // R8

   generate
      if (IRQ_REG) begin : g_irq_chk
         AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out == $past(any_pend));                                // R5
      end
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_ro
         AST_STATUS_NO_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_req && !drop_req) |=> $stable(stat_q[w]));           // R7
      end
   endgenerate
endmodule

bind netirq_agg netirq_chk #(
   .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W),
   .PORT_W(PORT_W), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .pend_req(pend_req), .pend_slot(pend_slot), .pend_port(pend_port),
   .drop_req(drop_req), .drop_slot(drop_slot), .drop_port(drop_port),
   .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .irq_out(irq_out),
   .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_netirq_agg.sv
`timescale 1ns/1ps
module sim_netirq_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pend_req = 1'b0, drop_req = 1'b0;
   logic [1:0]  pend_slot = '0, drop_slot = '0;
   logic [3:0]  pend_port = '0, drop_port = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_out;

   always #2 clk = ~clk;

   netirq_agg u0 (
      .clk(clk), .rst_n(rst_n),
      .pend_req(pend_req), .pend_slot(pend_slot), .pend_port(pend_port),
      .drop_req(drop_req), .drop_slot(drop_slot), .drop_port(drop_port),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   typedef struct { logic [15:0] val; string tag; } exp_t;
   exp_t exp_q[$];

   int n_run = 0, n_fail = 0;
   logic [15:0] m_word [2] = '{16'hFFFF, 16'hFFFF};
   logic [15:0] m_mask = 16'h0000;
   bit done = 0;

   function automatic logic m_irq();
      return (m_word[0] != 16'hFFFF) || (m_word[1] != 16'hFFFF);
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: compare read data right after the capturing edge.
   always @(posedge clk) begin
      automatic logic rd_now = bus_rd;
      #1;
      if (rd_now) begin
         if (exp_q.size() == 0) check("R6 no expected item", 16'h0, 16'h1);
         else begin
            automatic exp_t e = exp_q.pop_front();
            check(e.tag, bus_rdata, e.val);
         end
      end
   end

   task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back('{exp, tag});
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      if (a == 8'h30) m_mask = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // Drive one cycle of requests, update the model, check irq latency.
   task automatic requests(input bit p, input int ps, input int pp,
                           input bit d, input int ds, input int dp, input string tag);
      automatic logic old_irq = m_irq();
      @(negedge clk);
      pend_req = p; pend_slot = 2'(ps); pend_port = 4'(pp);
      drop_req = d; drop_slot = 2'(ds); drop_port = 4'(dp);
      if (d && ds < 2) m_word[ds][dp] = 1'b1;
      if (p && ps < 2) m_word[ps][pp] = 1'b0;
      @(negedge clk);
      pend_req = 1'b0; drop_req = 1'b0;
      check({tag, " R5 irq one-cycle lag"}, 16'(irq_out), 16'(old_irq));
      @(negedge clk);
      check({tag, " R5 irq level"}, 16'(irq_out), 16'(m_irq()));
   endtask

   task automatic read_all(input string tag);
      bus_read(8'h26, m_word[0], {tag, " word0"});
      bus_read(8'h28, m_word[1], {tag, " word1"});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq after reset", 16'(irq_out), 16'h0);
      check("R1 rdata after reset", bus_rdata, 16'h0);
      bus_read(8'h26, 16'hFFFF, "R1 word0 reset");
      bus_read(8'h28, 16'hFFFF, "R1 word1 reset");
      bus_read(8'h30, 16'h0000, "R1 mask reset");

      requests(1, 0, 3, 0, 0, 0, "R2 slot0 port3");
      read_all("R2 after slot0 port3");
      requests(1, 1, 0, 0, 0, 0, "R2 slot1 port0");
      read_all("R2 after slot1 port0");
      requests(0, 0, 0, 1, 0, 3, "R3 drop slot0 port3");
      read_all("R3 after drop");
      requests(0, 0, 0, 1, 1, 0, "R3 drop slot1 port0");
      read_all("R3 all idle");

      requests(1, 1, 7, 1, 1, 7, "R4 same-bit collision");
      read_all("R4 collision pending");
      requests(1, 0, 15, 1, 1, 7, "R4 distinct bits");
      read_all("R4 both applied");

      bus_write(8'h26, 16'h0000);
      bus_write(8'h28, 16'h1234);
      read_all("R7 writes ignored");

      bus_write(8'h30, 16'hA5C3);
      bus_read(8'h30, 16'hA5C3, "R8 mask readback");
      check("R8 mask leaves irq", 16'(irq_out), 16'(m_irq()));
      requests(0, 0, 0, 1, 0, 15, "R8 drop with mask set");
      bus_write(8'h30, 16'hFFFF);
      check("R8 mask leaves irq idle", 16'(irq_out), 16'h0);
      bus_read(8'h30, 16'hFFFF, "R8 mask second write");

      bus_read(8'h40, 16'h0000, "R6 unmapped offset");
      bus_read(8'h27, 16'h0000, "R6 odd offset");

      requests(1, 2, 5, 0, 0, 0, "R9 slot2 raise");
      requests(1, 3, 0, 0, 0, 0, "R9 slot3 raise");
      read_all("R9 out of range ignored");

      for (int i = 0; i < 16; i++) requests(1, 0, i, 0, 0, 0, "R2 fill word0");
      bus_read(8'h26, 16'h0000, "R2 all ports pending");
      requests(0, 0, 0, 1, 2, 0, "R9 slot2 drop");
      read_all("R9 drop ignored");

      repeat (3) @(negedge clk);
      check("R6 queue drained", 16'(exp_q.size()), 16'h0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule